// File: doc/BRIEF.md
# Secondary-side error status register

This block holds the error flags that the secondary side of a PCIe root or bridge port raises when something goes wrong downstream. The port logic reports each event as a one-cycle pulse. The block latches the pulse into a sticky flag that stays set until software clears it. Software reads the 16-bit register through a simple configuration access port. To clear flags, it writes ones to their positions; a write-one-to-clear scheme.

Five flags are implemented:

| Bit | Set when |
|-----|----------|
| 15 | a poisoned TLP is received |
| 14 | a fatal or non-fatal error message is received |
| 13 | an Unsupported Request completion is received |
| 12 | a Completer Abort completion is received |
| 8 | the parity-error-response enable is on, and either a poisoned completion arrives or the port forwards a poisoned write to the secondary side |

All other bits are constant zero.

Each flag is a two-state machine:

- **States.** FLAG_CLEAR and FLAG_LATCHED.
- **SET transition.** From FLAG_CLEAR to FLAG_LATCHED, taken when the flag's event term is true.
- **CLEAR transition.** From FLAG_LATCHED to FLAG_CLEAR, taken on a write-one clear in a cycle with no set.
- **HOLD.** Every other case keeps the current state.

A set in the same cycle as a clear keeps the flag latched.

Top module: `sts_sec_error`

## Requirements
- R1: After reset every bit reads 0 (register value 0000h).
- R2: Bit 15 becomes 1 in the cycle after `ev_poison_rx` or `ev_cpl_poison` is high.
- R3: Bit 14 becomes 1 in the cycle after `ev_err_msg` is high.
- R4: Bit 13 becomes 1 in the cycle after `ev_cpl_ur` is high.
- R5: Bit 12 becomes 1 in the cycle after `ev_cpl_ca` is high.
- R6: Bit 8 becomes 1 in the cycle after (`ev_cpl_poison` or `ev_wr_poison`) is high while `perr_resp_en` is 1. While `perr_resp_en` is 0 these events never set bit 8; a poisoned completion still sets bit 15.
- R7: A write with `cfg_wr`=1, `cfg_addr`=1Eh and `cfg_be[1]`=1 clears, in the next cycle, each of bits 15:12 and 8 whose `cfg_wdata` bit is 1. The following writes leave the register unchanged:
  - zero data bits;
  - `cfg_be[1]`=0 (byte enable bit 1 covers data bits 15:8, bit 0 covers bits 7:0);
  - any other address.
- R8: If a flag's event and its write-one clear occur in the same cycle, the flag is 1 afterwards.
- R9: Bits 11:9 and 7:0 always read 0, including after ones are written to them.
- R10: `cfg_rd`=1 with `cfg_addr`=1Eh makes `cfg_rdata` equal, one cycle later, to the register value before that clock edge. In every other cycle `cfg_rdata` is 0.
- R11: A set flag stays set while no clear for it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_poison_rx | input | 1 | Pulse: poisoned TLP received |
| ev_err_msg | input | 1 | Pulse: fatal or non-fatal error message received |
| ev_cpl_ur | input | 1 | Pulse: Unsupported Request completion received |
| ev_cpl_ca | input | 1 | Pulse: Completer Abort completion received |
| ev_cpl_poison | input | 1 | Pulse: poisoned completion received |
| ev_wr_poison | input | 1 | Pulse: port poisoned a write toward the secondary side |
| perr_resp_en | input | 1 | Parity-error-response enable |
| cfg_addr | input | ADDR_W | Config byte address |
| cfg_wr | input | 1 | Config write strobe |
| cfg_be | input | 2 | Byte enables (bit 1 = data bits 15:8) |
| cfg_wdata | input | 16 | Config write data |
| cfg_rd | input | 1 | Config read strobe |
| cfg_rdata | output | 16 | Read data, valid the cycle after `cfg_rd` |

## Verification
The assertions check several behaviours on every clock:

- that each event sets its flag one cycle later;
- that bit 8 never rises while the enable is off;
- that the register is stable when there is neither an event nor a write;
- that read data reflects the register as it stood at the read.

Only the bench scenarios can show the rest: that clears honour the data mask, the byte enable and the address; that a set beats a simultaneous clear; and that writes to the read-only positions are ignored. These are compared against a behavioural model every clock.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int STS_W   = 16;
    localparam int N_FLAGS = 5;

    localparam int POS_POISON_RX = 15;
    localparam int POS_ERR_MSG   = 14;
    localparam int POS_UR_CPL    = 13;
    localparam int POS_CA_CPL    = 12;
    localparam int POS_DATA_PERR = 8;

    typedef enum logic {
        FLAG_CLEAR   = 1'b0,
        FLAG_LATCHED = 1'b1
    } flag_state_e;

    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return POS_POISON_RX;
            1:       return POS_ERR_MSG;
            2:       return POS_UR_CPL;
            3:       return POS_CA_CPL;
            default: return POS_DATA_PERR;
        endcase
    endfunction
endpackage

// File: rtl/sts_flag.sv
module sts_flag
    import sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:   if (set_i) state_d = FLAG_LATCHED;
            FLAG_LATCHED: if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:      state_d = FLAG_CLEAR;
        endcase
    end

    always_comb q_o = (state_q == FLAG_LATCHED);
endmodule

// File: rtl/sts_cfg_decode.sv
module sts_cfg_decode
    import sts_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1E
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_be,
    input  logic [STS_W-1:0]  cfg_wdata,
    output logic              hit_o,
    output logic [STS_W-1:0]  clr_mask_o
);
    localparam int BYTE_W = STS_W / 2;

    always_comb begin
        hit_o      = (cfg_addr == REG_OFFSET);
        clr_mask_o = '0;
        if (cfg_wr && hit_o)
            clr_mask_o = cfg_wdata & {{BYTE_W{cfg_be[1]}}, {BYTE_W{cfg_be[0]}}};
    end
endmodule

// File: rtl/sts_event_map.sv
module sts_event_map
    import sts_pkg::*;
(
    input  logic               ev_poison_rx,
    input  logic               ev_err_msg,
    input  logic               ev_cpl_ur,
    input  logic               ev_cpl_ca,
    input  logic               ev_cpl_poison,
    input  logic               ev_wr_poison,
    input  logic               perr_resp_en,
    output logic [N_FLAGS-1:0] set_o
);
    always_comb begin
        set_o[0] = ev_poison_rx | ev_cpl_poison;
        set_o[1] = ev_err_msg;
        set_o[2] = ev_cpl_ur;
        set_o[3] = ev_cpl_ca;
        set_o[4] = perr_resp_en & (ev_cpl_poison | ev_wr_poison);
    end
endmodule

// File: rtl/sts_sec_error.sv
module sts_sec_error
    import sts_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_poison_rx,
    input  logic              ev_err_msg,
    input  logic              ev_cpl_ur,
    input  logic              ev_cpl_ca,
    input  logic              ev_cpl_poison,
    input  logic              ev_wr_poison,
    input  logic              perr_resp_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_be,
    input  logic [STS_W-1:0]  cfg_wdata,
    input  logic              cfg_rd,
    output logic [STS_W-1:0]  cfg_rdata
);
    logic               hit;
    logic [STS_W-1:0]   clr_mask;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] flag_q;
    logic [STS_W-1:0]   sts;

    sts_cfg_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
        .cfg_addr   (cfg_addr),
        .cfg_wr     (cfg_wr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .hit_o      (hit),
        .clr_mask_o (clr_mask)
    );

    sts_event_map u_map (
        .ev_poison_rx  (ev_poison_rx),
        .ev_err_msg    (ev_err_msg),
        .ev_cpl_ur     (ev_cpl_ur),
        .ev_cpl_ca     (ev_cpl_ca),
        .ev_cpl_poison (ev_cpl_poison),
        .ev_wr_poison  (ev_wr_poison),
        .perr_resp_en  (perr_resp_en),
        .set_o         (set_vec)
    );

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        sts_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_mask[flag_pos(i)]),
            .q_o   (flag_q[i])
        );
    end

    always_comb begin
        sts = '0;
        for (int i = 0; i < N_FLAGS; i++) sts[flag_pos(i)] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cfg_rdata <= '0;
        else if (cfg_rd && hit) cfg_rdata <= sts;
        else                    cfg_rdata <= '0;
    end
endmodule

// File: rtl/sts_sec_error_chk.sv
module sts_sec_error_chk
    import sts_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_poison_rx,
    input logic              ev_err_msg,
    input logic              ev_cpl_ur,
    input logic              ev_cpl_ca,
    input logic              ev_cpl_poison,
    input logic              ev_wr_poison,
    input logic              perr_resp_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [STS_W-1:0]  sts,
    input logic [STS_W-1:0]  cfg_rdata
);
    logic any_ev;
    assign any_ev = ev_poison_rx | ev_err_msg | ev_cpl_ur | ev_cpl_ca | ev_cpl_poison | ev_wr_poison;

    AST_POISON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_poison_rx || ev_cpl_poison) |=> sts[15]);                          // R2
    AST_ERRMSG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err_msg |=> sts[14]);                                               // R3
    AST_UR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cpl_ur |=> sts[13]);                                                // R4
    AST_CA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cpl_ca |=> sts[12]);                                                // R5
    AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_resp_en |=> !$rose(sts[8]));                                     // R6
    AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_resp_en && (ev_cpl_poison || ev_wr_poison)) |=> sts[8]);         // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !cfg_wr) |=> $stable(sts));                                // R11
    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == REG_OFFSET) |=> cfg_rdata == $past(sts));       // R10
    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd && cfg_addr == REG_OFFSET) |=> cfg_rdata == '0);              // R10
endmodule

bind sts_sec_error sts_sec_error_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_poison_rx  (ev_poison_rx),
    .ev_err_msg    (ev_err_msg),
    .ev_cpl_ur     (ev_cpl_ur),
    .ev_cpl_ca     (ev_cpl_ca),
    .ev_cpl_poison (ev_cpl_poison),
    .ev_wr_poison  (ev_wr_poison),
    .perr_resp_en  (perr_resp_en),
    .cfg_addr      (cfg_addr),
    .cfg_wr        (cfg_wr),
    .cfg_rd        (cfg_rd),
    .sts           (sts),
    .cfg_rdata     (cfg_rdata)
);

// File: tb/sts_sec_error_test.sv
module sts_sec_error_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_poison_rx = 0, ev_err_msg = 0, ev_cpl_ur = 0, ev_cpl_ca = 0;
    logic        ev_cpl_poison = 0, ev_wr_poison = 0, perr_resp_en = 0;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sts_sec_error uut (
        .clk(clk), .rst_n(rst_n),
        .ev_poison_rx(ev_poison_rx), .ev_err_msg(ev_err_msg), .ev_cpl_ur(ev_cpl_ur),
        .ev_cpl_ca(ev_cpl_ca), .ev_cpl_poison(ev_cpl_poison), .ev_wr_poison(ev_wr_poison),
        .perr_resp_en(perr_resp_en), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
    );

    // Behavioural reference model
    logic [15:0] m_sts;
    logic [15:0] m_rd;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts <= 16'h0;
            m_rd  <= 16'h0;
        end else begin
            logic [15:0] setm, clrm;
            setm = 16'h0;
            if (ev_poison_rx || ev_cpl_poison) setm[15] = 1'b1;
            if (ev_err_msg) setm[14] = 1'b1;
            if (ev_cpl_ur)  setm[13] = 1'b1;
            if (ev_cpl_ca)  setm[12] = 1'b1;
            if (perr_resp_en && (ev_cpl_poison || ev_wr_poison)) setm[8] = 1'b1;
            clrm = 16'h0;
            if (cfg_wr && cfg_addr == 8'h1E && cfg_be[1]) clrm = cfg_wdata & 16'hF100;
            m_sts <= (m_sts & ~clrm) | setm;
            m_rd  <= (cfg_rd && cfg_addr == 8'h1E) ? m_sts : 16'h0;
        end
    end

    // Every-cycle comparison of the read port against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (cfg_rdata !== m_rd) begin
                errors++;
                $display("FAIL R10 model compare: actual %h expected %h", cfg_rdata, m_rd);
            end
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string tag);
        cfg_rd = 1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 0;
        check(cfg_rdata, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 0; cfg_be = 2'b00; cfg_wdata = 16'h0;
    endtask

    // mask order: poison_rx, err_msg, ur, ca, cpl_poison, wr_poison
    task automatic pulse(input logic [5:0] m);
        {ev_poison_rx, ev_err_msg, ev_cpl_ur, ev_cpl_ca, ev_cpl_poison, ev_wr_poison} = m;
        @(negedge clk);
        {ev_poison_rx, ev_err_msg, ev_cpl_ur, ev_cpl_ca, ev_cpl_poison, ev_wr_poison} = 6'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_check(8'h1E, 16'h0000, "R1 reset value");

        pulse(6'b010000); rd_check(8'h1E, 16'h4000, "R3 error message");
        wr(8'h1E, 16'h4000, 2'b10); rd_check(8'h1E, 16'h0000, "R7 clear bit14");
        pulse(6'b001000); rd_check(8'h1E, 16'h2000, "R4 UR completion");
        pulse(6'b000100); rd_check(8'h1E, 16'h3000, "R5 CA completion");
        pulse(6'b100000); rd_check(8'h1E, 16'hB000, "R2 poisoned TLP");

        wr(8'h1E, 16'h0000, 2'b11); rd_check(8'h1E, 16'hB000, "R7 zero data no effect");
        wr(8'h1E, 16'hFFFF, 2'b01); rd_check(8'h1E, 16'hB000, "R7 upper byte disabled");
        wr(8'h1C, 16'hFFFF, 2'b11); rd_check(8'h1E, 16'hB000, "R7 other address");
        rd_check(8'h1C, 16'h0000, "R10 other address reads zero");
        wr(8'h1E, 16'h2000, 2'b10); rd_check(8'h1E, 16'h9000, "R7 clear bit13 only");
        repeat (20) @(negedge clk);
        rd_check(8'h1E, 16'h9000, "R11 flags held");
        wr(8'h1E, 16'hFFFF, 2'b11); rd_check(8'h1E, 16'h0000, "R7 clear all");

        perr_resp_en = 0;
        pulse(6'b000010); rd_check(8'h1E, 16'h8000, "R6 gated cpl poison");
        pulse(6'b000001); rd_check(8'h1E, 16'h8000, "R6 gated write poison");
        wr(8'h1E, 16'hFFFF, 2'b10);
        perr_resp_en = 1;
        pulse(6'b000001); rd_check(8'h1E, 16'h0100, "R6 write poison enabled");
        wr(8'h1E, 16'h0100, 2'b10);
        pulse(6'b000010); rd_check(8'h1E, 16'h8100, "R2 R6 cpl poison sets both");

        // set wins over same-cycle clear
        ev_cpl_ur = 1; cfg_wr = 1; cfg_addr = 8'h1E; cfg_wdata = 16'h2000; cfg_be = 2'b10;
        @(negedge clk);
        ev_cpl_ur = 0; cfg_wr = 0; cfg_be = 2'b00; cfg_wdata = 16'h0;
        rd_check(8'h1E, 16'hA100, "R8 set beats clear");

        pulse(6'b111111);
        rd_check(8'h1E, 16'hF100, "R9 all flags set");
        wr(8'h1E, 16'h0EFF, 2'b11); rd_check(8'h1E, 16'hF100, "R9 read-only bits stay zero");
        wr(8'h1E, 16'hF100, 2'b11); rd_check(8'h1E, 16'h0000, "R7 final clear");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule